// File: doc/BRIEF.md
# Inter-task register reservation unit

This block keeps register dependences correct between speculative tasks that occupy a small ring of execution slots. Tasks enter the ring at the tail and retire from the head, both in ring order. Each arriving task supplies a create mask. The mask has one bit per architectural register and names every register the task might write. The unit keeps, for each live slot, the set of registers that slot may still produce. A slot's reservation for a register is the OR of those pending sets over all older live slots. A read from a slot stalls while the register it names is reserved for that slot.

Pending bits are cleared in three ways. A register write that carries the forward flag clears one bit. An explicit release mask clears the registers a task turns out not to write. A stop event marks the task's last instruction and clears whatever the task still holds. Reservations are always derived from the live pending sets, so a forward from one slot unblocks younger slots only up to the next older slot that also creates that register. A squash restarts a task with its full create mask, and the younger slots' reservations are rebuilt from that mask at once. Each slot runs a three-state machine: FREE, RUN and DONE. The transitions are ALLOC (FREE to RUN), STOP (RUN to DONE), RESTART (RUN or DONE to RUN, on squash) and RETIRE (DONE to FREE, on commit of the head).

Top module: `rr_unit`

## Requirements
- R1: After reset every slot is FREE, the ring is empty (`ring_empty`=1, `ring_full`=0), `head_slot`=0, `tail_slot`=0, and no read stalls.
- R2: `assign_valid` while the ring is not full ALLOCs the tail slot with `assign_mask` as its create mask, and the tail advances by one modulo the slot count. While the ring is full the request is ignored and the tail holds.
- R3: `rd_stall` is 1 exactly when `rd_valid` is 1, slot `rd_slot` is live, and some live slot older than it in ring order (from the head) still has bit `rd_reg` pending.
- R4: A write with `wr_fwd`=1 from a RUN slot clears that register's pending bit. Younger slots stop stalling on it unless a slot between them still holds the register pending.
- R5: A write with `wr_fwd`=0 changes no reservation.
- R6: `stop_valid` on a RUN slot moves it to DONE and clears all its pending bits in the same step.
- R7: `rel_valid` clears the bits of `rel_mask` from the pending set of a RUN slot `rel_slot`.
- R8: `squash_valid` on a RUN or DONE slot returns it to RUN with its full create mask pending. Squash takes priority over stop, write, release and commit on that slot in the same cycle. A squash of a FREE slot is ignored.
- R9: `commit_valid` RETIREs the head slot only when it is DONE and not squashed in that cycle, and the head then advances. Otherwise the commit is ignored.
- R10: A read from the head slot or from a FREE slot never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| assign_valid | input | 1 | Allocate a task at the tail |
| assign_mask | input | NREG | Create mask of the new task |
| wr_valid | input | 1 | Register write event |
| wr_slot | input | log2(NSLOT) | Slot performing the write |
| wr_reg | input | log2(NREG) | Register written |
| wr_fwd | input | 1 | Write forwards its value to successors |
| stop_valid | input | 1 | Task end marker seen |
| stop_slot | input | log2(NSLOT) | Slot whose task ended |
| rel_valid | input | 1 | Release event |
| rel_slot | input | log2(NSLOT) | Slot releasing registers |
| rel_mask | input | NREG | Registers released |
| squash_valid | input | 1 | Restart a task |
| squash_slot | input | log2(NSLOT) | Slot to restart |
| commit_valid | input | 1 | Request retirement of the head |
| rd_valid | input | 1 | Register read request |
| rd_slot | input | log2(NSLOT) | Slot issuing the read |
| rd_reg | input | log2(NREG) | Register read |
| rd_stall | output | 1 | Read must wait |
| head_slot | output | log2(NSLOT) | Oldest slot |
| tail_slot | output | log2(NSLOT) | Next slot to allocate |
| ring_full | output | 1 | All slots live |
| ring_empty | output | 1 | No slot live |

## Verification
Assertions check on every cycle that an empty ring and a head-slot read never stall, and that a stall only names a live slot. They also check that a refused allocation leaves the tail unchanged and that a stopped slot holds nothing pending afterwards. Only the bench scenarios can show the exact reservation pattern. That covers the cut-off of a forward at a later creator of the same register, release, and the rebuild of younger reservations after a squash. It also covers the ordering of commit against squash, all compared against an independent ring model over many random event mixes.

// File: rtl/rr_pkg.sv
package rr_pkg;
    typedef enum logic [1:0] {
        SL_FREE = 2'd0,
        SL_RUN  = 2'd1,
        SL_DONE = 2'd2
    } slot_state_e;
endpackage

// File: rtl/rr_slot.sv
module rr_slot #(
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_en,
    input  logic [NREG-1:0]         alloc_mask,
    input  logic                    fwd_en,
    input  logic [$clog2(NREG)-1:0] fwd_reg,
    input  logic                    stop_en,
    input  logic                    rel_en,
    input  logic [NREG-1:0]         rel_mask,
    input  logic                    squash_en,
    input  logic                    retire_en,
    output rr_pkg::slot_state_e     state_o,
    output logic [NREG-1:0]         pend_o
);
    import rr_pkg::*;

    slot_state_e     state_q, state_d;
    logic [NREG-1:0] pend_q, pend_d;
    logic [NREG-1:0] create_q, create_d;
    logic [NREG-1:0] clr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SL_FREE;
            pend_q   <= '0;
            create_q <= '0;
        end else begin
            state_q  <= state_d;
            pend_q   <= pend_d;
            create_q <= create_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        pend_d   = pend_q;
        create_d = create_q;
        clr      = '0;
        if (fwd_en) clr[fwd_reg] = 1'b1;
        if (rel_en) clr = clr | rel_mask;
        unique case (state_q)
            SL_FREE: begin
                if (alloc_en) begin          // ALLOC
                    state_d  = SL_RUN;
                    pend_d   = alloc_mask;
                    create_d = alloc_mask;
                end
            end
            SL_RUN: begin
                if (squash_en) begin         // RESTART
                    pend_d = create_q;
                end else if (stop_en) begin  // STOP
                    state_d = SL_DONE;
                    pend_d  = '0;
                end else begin
                    pend_d = pend_q & ~clr;
                end
            end
            SL_DONE: begin
                if (squash_en) begin         // RESTART
                    state_d = SL_RUN;
                    pend_d  = create_q;
                end else if (retire_en) begin // RETIRE
                    state_d = SL_FREE;
                end
            end
            default: state_d = SL_FREE;
        endcase
    end

    // outputs
    always_comb begin
        state_o = state_q;
        pend_o  = pend_q;
    end
endmodule

// File: rtl/rr_resv.sv
module rr_resv #(
    parameter int NSLOT = 4,
    parameter int NREG  = 32
) (
    input  logic [NSLOT-1:0]            active,
    input  logic [NSLOT-1:0][NREG-1:0]  pend,
    input  logic [$clog2(NSLOT)-1:0]    head,
    output logic [NSLOT-1:0][NREG-1:0]  resv
);
    localparam int SW = $clog2(NSLOT);

    for (genvar s = 0; s < NSLOT; s++) begin : g_row
        always_comb begin
            logic [SW-1:0]   age_s;
            logic [SW-1:0]   age_p;
            logic [NREG-1:0] acc;
            age_s = SW'(s) - head;
            acc   = '0;
            for (int p = 0; p < NSLOT; p++) begin
                age_p = SW'(p) - head;
                if (active[p] && (age_p < age_s)) acc = acc | pend[p];
            end
            resv[s] = acc;
        end
    end
endmodule

// File: rtl/rr_ring.sv
module rr_ring #(
    parameter int NSLOT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_req,
    input  logic                     retire_ok,
    output logic                     alloc_ok,
    output logic [$clog2(NSLOT)-1:0] head,
    output logic [$clog2(NSLOT)-1:0] tail,
    output logic                     full,
    output logic                     empty
);
    localparam int SW = $clog2(NSLOT);
    localparam int CW = SW + 1;

    logic [CW-1:0] cnt_q;
    logic [SW-1:0] head_q, tail_q;

    always_comb begin
        full     = (cnt_q == CW'(NSLOT));
        empty    = (cnt_q == '0);
        alloc_ok = alloc_req && !full;
        head     = head_q;
        tail     = tail_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (alloc_ok)  tail_q <= tail_q + 1'b1;
            if (retire_ok) head_q <= head_q + 1'b1;
            cnt_q <= cnt_q + CW'(alloc_ok) - CW'(retire_ok);
        end
    end
endmodule

// File: rtl/rr_unit.sv
module rr_unit #(
    parameter int NSLOT = 4,
    parameter int NREG  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     assign_valid,
    input  logic [NREG-1:0]          assign_mask,
    input  logic                     wr_valid,
    input  logic [$clog2(NSLOT)-1:0] wr_slot,
    input  logic [$clog2(NREG)-1:0]  wr_reg,
    input  logic                     wr_fwd,
    input  logic                     stop_valid,
    input  logic [$clog2(NSLOT)-1:0] stop_slot,
    input  logic                     rel_valid,
    input  logic [$clog2(NSLOT)-1:0] rel_slot,
    input  logic [NREG-1:0]          rel_mask,
    input  logic                     squash_valid,
    input  logic [$clog2(NSLOT)-1:0] squash_slot,
    input  logic                     commit_valid,
    input  logic                     rd_valid,
    input  logic [$clog2(NSLOT)-1:0] rd_slot,
    input  logic [$clog2(NREG)-1:0]  rd_reg,
    output logic                     rd_stall,
    output logic [$clog2(NSLOT)-1:0] head_slot,
    output logic [$clog2(NSLOT)-1:0] tail_slot,
    output logic                     ring_full,
    output logic                     ring_empty
);
    import rr_pkg::*;

    localparam int SW = $clog2(NSLOT);

    slot_state_e                slot_st [NSLOT];
    logic [NSLOT-1:0]           slot_active;
    logic [NSLOT-1:0]           slot_done;
    logic [NSLOT-1:0][NREG-1:0] slot_pend;
    logic [NSLOT-1:0][NREG-1:0] slot_resv;
    logic                       alloc_ok;
    logic                       retire_ok;
    logic                       squash_head;

    assign squash_head = squash_valid && (squash_slot == head_slot);
    assign retire_ok   = commit_valid && slot_done[head_slot] && !squash_head;

    rr_ring #(.NSLOT(NSLOT)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_req (assign_valid),
        .retire_ok (retire_ok),
        .alloc_ok  (alloc_ok),
        .head      (head_slot),
        .tail      (tail_slot),
        .full      (ring_full),
        .empty     (ring_empty)
    );

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        rr_slot #(.NREG(NREG)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_en   (alloc_ok && (tail_slot == SW'(k))),
            .alloc_mask (assign_mask),
            .fwd_en     (wr_valid && wr_fwd && (wr_slot == SW'(k))),
            .fwd_reg    (wr_reg),
            .stop_en    (stop_valid && (stop_slot == SW'(k))),
            .rel_en     (rel_valid && (rel_slot == SW'(k))),
            .rel_mask   (rel_mask),
            .squash_en  (squash_valid && (squash_slot == SW'(k))),
            .retire_en  (retire_ok && (head_slot == SW'(k))),
            .state_o    (slot_st[k]),
            .pend_o     (slot_pend[k])
        );
        assign slot_active[k] = (slot_st[k] != SL_FREE);
        assign slot_done[k]   = (slot_st[k] == SL_DONE);
    end

    rr_resv #(.NSLOT(NSLOT), .NREG(NREG)) u_resv (
        .active (slot_active),
        .pend   (slot_pend),
        .head   (head_slot),
        .resv   (slot_resv)
    );

    assign rd_stall = rd_valid && slot_active[rd_slot] && slot_resv[rd_slot][rd_reg];
endmodule

// File: rtl/rr_unit_chk.sv
module rr_unit_chk #(
    parameter int NSLOT = 4,
    parameter int NREG  = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       assign_valid,
    input logic                       stop_valid,
    input logic [$clog2(NSLOT)-1:0]   stop_slot,
    input logic                       squash_valid,
    input logic [$clog2(NSLOT)-1:0]   squash_slot,
    input logic                       rd_valid,
    input logic [$clog2(NSLOT)-1:0]   rd_slot,
    input logic                       rd_stall,
    input logic [$clog2(NSLOT)-1:0]   head_slot,
    input logic [$clog2(NSLOT)-1:0]   tail_slot,
    input logic                       ring_full,
    input logic                       ring_empty,
    input logic [NSLOT-1:0]           slot_active,
    input logic [NSLOT-1:0][NREG-1:0] slot_pend
);
    // R1
    empty_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_empty |-> !rd_stall);

    // R10
    head_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_slot == head_slot) |-> !rd_stall);

    // R3
    stall_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stall |-> slot_active[rd_slot]);

    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_full && assign_valid) |=> $stable(tail_slot));

    // R2
    full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ring_full && ring_empty));

    // R6
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_valid && slot_active[stop_slot] && !(squash_valid && squash_slot == stop_slot))
        |=> (slot_pend[$past(stop_slot)] == '0));
endmodule

bind rr_unit rr_unit_chk #(.NSLOT(NSLOT), .NREG(NREG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .assign_valid (assign_valid),
    .stop_valid   (stop_valid),
    .stop_slot    (stop_slot),
    .squash_valid (squash_valid),
    .squash_slot  (squash_slot),
    .rd_valid     (rd_valid),
    .rd_slot      (rd_slot),
    .rd_stall     (rd_stall),
    .head_slot    (head_slot),
    .tail_slot    (tail_slot),
    .ring_full    (ring_full),
    .ring_empty   (ring_empty),
    .slot_active  (slot_active),
    .slot_pend    (slot_pend)
);

// File: tb/test_rr_unit.sv
module test_rr_unit;
    localparam int NS = 4;
    localparam int NR = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          assign_valid, wr_valid, wr_fwd, stop_valid, rel_valid;
    logic          squash_valid, commit_valid, rd_valid, rd_stall;
    logic [NR-1:0] assign_mask, rel_mask;
    logic [1:0]    wr_slot, stop_slot, rel_slot, squash_slot, rd_slot, head_slot, tail_slot;
    logic [4:0]    wr_reg, rd_reg;
    logic          ring_full, ring_empty;

    rr_unit #(.NSLOT(NS), .NREG(NR)) i_rr_unit (.*);

    // stimulus staging
    logic          g_as, g_wv, g_wf, g_sv, g_rv, g_qv, g_cv, g_rd;
    logic [NR-1:0] g_am, g_rm;
    logic [1:0]    g_ws, g_ss, g_rs, g_qs, g_rds;
    logic [4:0]    g_wr, g_rdr;
    logic          g_exp_en, g_exp;
    string         g_tag;

    // model
    int            mst [NS];
    logic [NR-1:0] mpend [NS];
    logic [NR-1:0] mcreate [NS];
    int            mhead, mtail, mcnt;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit model_resv(input int s, input int r);
        int as_;
        if (mst[s] == 0) return 1'b0;
        as_ = (s - mhead + NS) % NS;
        for (int a = 0; a < as_; a++) begin
            int p;
            p = (mhead + a) % NS;
            if (mst[p] != 0 && mpend[p][r]) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic clear_stim();
        g_as = 0; g_wv = 0; g_wf = 0; g_sv = 0; g_rv = 0; g_qv = 0; g_cv = 0; g_rd = 0;
        g_am = '0; g_rm = '0; g_ws = 0; g_ss = 0; g_rs = 0; g_qs = 0; g_rds = 0;
        g_wr = 0; g_rdr = 0; g_exp_en = 0; g_exp = 0; g_tag = "";
    endtask

    task automatic model_update();
        bit alloc, retire;
        alloc  = g_as && (mcnt < NS);
        retire = g_cv && (mst[mhead] == 2) && !(g_qv && g_qs == 2'(mhead));
        for (int k = 0; k < NS; k++) begin
            bit sq;
            sq = g_qv && (g_qs == 2'(k));
            case (mst[k])
                0: if (alloc && k == mtail) begin
                       mst[k] = 1; mpend[k] = g_am; mcreate[k] = g_am;
                   end
                1: if (sq) mpend[k] = mcreate[k];
                   else if (g_sv && g_ss == 2'(k)) begin mst[k] = 2; mpend[k] = '0; end
                   else begin
                       if (g_wv && g_wf && g_ws == 2'(k)) mpend[k][g_wr] = 1'b0;
                       if (g_rv && g_rs == 2'(k)) mpend[k] = mpend[k] & ~g_rm;
                   end
                default: if (sq) begin mst[k] = 1; mpend[k] = mcreate[k]; end
                         else if (retire && k == mhead) mst[k] = 0;
            endcase
        end
        if (alloc)  mtail = (mtail + 1) % NS;
        if (retire) mhead = (mhead + 1) % NS;
        mcnt = mcnt + int'(alloc) - int'(retire);
    endtask

    task automatic tick();
        @(negedge clk);
        assign_valid = g_as; assign_mask = g_am;
        wr_valid = g_wv; wr_slot = g_ws; wr_reg = g_wr; wr_fwd = g_wf;
        stop_valid = g_sv; stop_slot = g_ss;
        rel_valid = g_rv; rel_slot = g_rs; rel_mask = g_rm;
        squash_valid = g_qv; squash_slot = g_qs;
        commit_valid = g_cv;
        rd_valid = g_rd; rd_slot = g_rds; rd_reg = g_rdr;
        #1;
        chk(int'(rd_stall), int'(g_rd && model_resv(int'(g_rds), int'(g_rdr))), "R3 stall vs model");
        chk(int'(head_slot), mhead, "R9 head");
        chk(int'(tail_slot), mtail, "R2 tail");
        chk(int'(ring_full), int'(mcnt == NS), "R2 full");
        chk(int'(ring_empty), int'(mcnt == 0), "R2 empty");
        if (g_exp_en) chk(int'(rd_stall), int'(g_exp), g_tag);
        @(posedge clk);
        model_update();
        clear_stim();
    endtask

    task automatic do_assign(input logic [NR-1:0] m);
        g_as = 1; g_am = m; tick();
    endtask

    task automatic probe(input int s, input int r, input bit e, input string tag);
        g_rd = 1; g_rds = 2'(s); g_rdr = 5'(r); g_exp_en = 1; g_exp = e; g_tag = tag; tick();
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < NS; k++) begin mst[k] = 0; mpend[k] = '0; mcreate[k] = '0; end
        mhead = 0; mtail = 0; mcnt = 0;
        clear_stim();
        assign_valid = 0; assign_mask = '0; wr_valid = 0; wr_slot = 0; wr_reg = 0; wr_fwd = 0;
        stop_valid = 0; stop_slot = 0; rel_valid = 0; rel_slot = 0; rel_mask = '0;
        squash_valid = 0; squash_slot = 0; commit_valid = 0; rd_valid = 0; rd_slot = 0; rd_reg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        #1;
        chk(int'(ring_empty), 1, "R1 empty");
        chk(int'(ring_full), 0, "R1 full");
        chk(int'(head_slot), 0, "R1 head");
        chk(int'(tail_slot), 0, "R1 tail");
        probe(2, 5, 0, "R1 no stall after reset");

        // slot0 creates r5,r3; slot1 r5; slot2 r9
        do_assign(32'h0000_0028);
        do_assign(32'h0000_0020);
        do_assign(32'h0000_0200);
        probe(2, 5, 1, "R3 slot2 r5 reserved");
        probe(1, 3, 1, "R3 slot1 r3 reserved");
        probe(0, 5, 0, "R10 head never stalls");
        probe(2, 9, 0, "R3 own create not reserved");
        probe(3, 5, 0, "R10 free slot never stalls");

        // R5 write without forward
        g_wv = 1; g_ws = 0; g_wr = 5; g_wf = 0; tick();
        probe(1, 5, 1, "R5 unforwarded write keeps stall");

        // R4 forward stops at next creator
        g_wv = 1; g_ws = 0; g_wr = 5; g_wf = 1; tick();
        probe(1, 5, 0, "R4 forward releases slot1");
        probe(2, 5, 1, "R4 slot2 still held by slot1");

        // R7 release
        g_rv = 1; g_rs = 0; g_rm = 32'h0000_0008; tick();
        probe(1, 3, 0, "R7 release clears r3");

        // R9 commit of RUN head ignored
        g_cv = 1; tick();
        chk(int'(head_slot), 0, "R9 commit ignored while running");

        // R6 stop releases remaining
        g_sv = 1; g_ss = 1; tick();
        probe(2, 5, 0, "R6 stop releases r5");

        // R8 squash rebuilds successor reservation
        g_qv = 1; g_qs = 1; tick();
        probe(2, 5, 1, "R8 squash restores reservation");

        // R2 fill and overflow
        do_assign(32'h0000_0001);
        do_assign(32'h0000_0002);
        #1;
        chk(int'(ring_full), 1, "R2 full after four");
        chk(int'(tail_slot), 0, "R2 tail unchanged on overflow");

        // R9 stop head, then commit with squash of head ignored, then commit
        g_sv = 1; g_ss = 0; tick();
        g_cv = 1; g_qv = 1; g_qs = 0; tick();
        #1; chk(int'(head_slot), 0, "R8 squash beats commit");
        g_sv = 1; g_ss = 0; tick();
        g_cv = 1; tick();
        #1; chk(int'(head_slot), 1, "R9 commit advances head");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            g_as = ($urandom % 100) < 30;
            g_am = $urandom & $urandom & 32'h0000_00FF;
            g_wv = ($urandom % 100) < 40;
            g_ws = 2'($urandom); g_wr = 5'($urandom % 8); g_wf = $urandom % 2;
            g_sv = ($urandom % 100) < 12; g_ss = 2'($urandom);
            g_rv = ($urandom % 100) < 10; g_rs = 2'($urandom);
            g_rm = $urandom & $urandom & 32'h0000_00FF;
            g_qv = ($urandom % 100) < 4; g_qs = 2'($urandom);
            g_cv = ($urandom % 100) < 35;
            g_rd = ($urandom % 100) < 90; g_rds = 2'($urandom);
            g_rdr = 5'((($urandom % 10) == 0) ? $urandom : ($urandom % 8));
            tick();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule